// File: doc/BRIEF.md
# Programmable-Priority Stream Arbiter

This block decides which of eight DMA streams owns a shared bus. Every stream has a request line and a 2-bit priority level that software sets through a simple register write port. When the bus is free and at least one stream is requesting, the arbiter picks a winner in two steps. The highest priority level among the requesters wins first. If several requesters share that level, the stream with the smallest index wins.

The winner is reported as a one-hot grant vector, an encoded grant index and a valid flag. The grant is registered and stays fixed until the winning stream pulses its done line. Request changes, done pulses from other streams and priority writes cannot move a grant while it is active. After a release, the next decision uses the requests and priorities present at that time.

Bus protocol, address generation and transfer counting belong to the neighbouring logic.

Top module: `stream_prio_arbiter`

## Requirements
- R1: While rst_n is low and after it is released, grant_o is 0, grant_vld_o is 0, grant_idx_o is 0, and every stream's priority level is low (0).
- R2: A cycle with cfg_we_i high writes bits [17:16] of cfg_wdata_i into the priority of stream cfg_sel_i. The encoding is 0 = low, 1 = medium, 2 = high, 3 = very high. All other bits of cfg_wdata_i are ignored.
- R3: When the bus is free and streams at different levels request together, a stream at the highest requesting level is granted.
- R4: Among requesters at the winning level, the lowest stream index is granted.
- R5: When the bus is free and req_i is non-zero at a rising edge, then after that edge grant_vld_o is 1, grant_o has exactly bit grant_idx_o set, and grant_idx_o is the winning stream.
- R6: While a grant is active, grant_o and grant_idx_o stay unchanged whatever req_i does. A done_i bit from any stream other than the granted one has no effect.
- R7: done_i[grant_idx_o] high at a rising edge clears the grant after that edge. The next rising edge arbitrates among the requests present then, so there is one free cycle between grants.
- R8: A priority write made while a grant is active does not change that grant. The new level is used from the next decision onward.
- R9: With no request pending and no grant active, grant_o stays 0, grant_vld_o stays 0 and grant_idx_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous |
| req_i | input | 8 | Request line per stream |
| done_i | input | 8 | End-of-transfer pulse per stream; only the granted stream's bit counts |
| cfg_we_i | input | 1 | Priority register write strobe |
| cfg_sel_i | input | 3 | Stream index being written |
| cfg_wdata_i | input | 32 | Control word; bits [17:16] hold the priority level |
| grant_o | output | 8 | One-hot grant, all zero when the bus is free |
| grant_idx_o | output | 3 | Encoded index of the granted stream, 0 when the bus is free |
| grant_vld_o | output | 1 | High while a grant is active |

## Verification
A wrong stored priority does not show up until a decision involves that stream against a rival at a different level. At that decision the wrong winner appears one cycle after the request edge. The bench therefore sweeps every request pattern under several level assignments. A held-index register that changes while the bus is owned shows up in the very next cycle as a moved grant. A missed or misrouted done shows up one cycle after the pulse as a grant that stays valid or is dropped when it should not be. Each of these is sampled exactly one edge after its cause.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } prio_lvl_e;

  typedef enum logic {
    ARB_FREE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;

endpackage

// File: rtl/sarb_prio_regs.sv
module sarb_prio_regs #(
  parameter int NUM_STREAMS = 8,
  parameter int LVL_W       = 2,
  parameter int CTRL_W      = 32,
  parameter int PRIO_LSB    = 16,
  parameter int IDX_W       = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_sel,
  input  logic [CTRL_W-1:0]                   wr_data,
  output logic [NUM_STREAMS-1:0][LVL_W-1:0]   prio_q
);

  localparam int FIELD_HI = PRIO_LSB + LVL_W - 1;

  logic [LVL_W-1:0] field;
  logic             ctrl_unused;

  assign field       = wr_data[FIELD_HI:PRIO_LSB];
  assign ctrl_unused = ^{wr_data[CTRL_W-1:FIELD_HI+1], wr_data[PRIO_LSB-1:0]};

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot
    logic             slot_en;
    logic [LVL_W-1:0] slot_d;

    always_comb begin
      slot_en = wr_en && (wr_sel == IDX_W'(s));
      slot_d  = slot_en ? field : prio_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[s] <= LVL_W'(stream_arb_pkg::LVL_LOW);
      end else if (slot_en) begin
        prio_q[s] <= slot_d;
      end
    end

    // R2
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == IDX_W'(s)) |=> (prio_q[s] == $past(field)));

    // R2
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == IDX_W'(s)) |=> $stable(prio_q[s]));
  end

endmodule

// File: rtl/sarb_select.sv
module sarb_select #(
  parameter int NUM_STREAMS = 8,
  parameter int LVL_W       = 2,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_STREAMS-1:0]              req,
  input  logic [NUM_STREAMS-1:0][LVL_W-1:0]   prio,
  output logic                                any_req,
  output logic [IDX_W-1:0]                    win_idx
);

  localparam int NUM_LVL = 1 << LVL_W;

  logic [NUM_LVL-1:0]            lvl_hit;
  logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx;

  // First stage: per level, lowest-index requester at that level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_comb begin
      lvl_hit[l] = 1'b0;
      lvl_idx[l] = '0;
      for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
        if (req[i] && (prio[i] == LVL_W'(l))) begin
          lvl_hit[l] = 1'b1;
          lvl_idx[l] = IDX_W'(i);
        end
      end
    end
  end

  // Second stage: highest non-empty level
  always_comb begin
    win_idx = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_hit[l]) begin
        win_idx = lvl_idx[l];
      end
    end
  end

  assign any_req = |req;

  // R3
  win_requests_chk: assert final (!any_req || req[win_idx]);

endmodule

// File: rtl/sarb_grant_hold.sv
module sarb_grant_hold #(
  parameter int NUM_STREAMS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   any_req,
  input  logic [IDX_W-1:0]       win_idx,
  input  logic [NUM_STREAMS-1:0] done,
  output logic [NUM_STREAMS-1:0] grant,
  output logic [IDX_W-1:0]       grant_idx,
  output logic                   grant_vld
);
  import stream_arb_pkg::*;

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             owner_done;

  assign owner_done = (state_q == ARB_OWNED) && done[idx_q];

  always_comb begin
    state_d = state_q;
    idx_en  = 1'b0;
    idx_d   = idx_q;
    unique case (state_q)
      ARB_FREE: begin
        if (any_req) begin
          state_d = ARB_OWNED;
          idx_en  = 1'b1;
          idx_d   = win_idx;
        end
      end
      ARB_OWNED: begin
        if (owner_done) begin
          state_d = ARB_FREE;
          idx_en  = 1'b1;
          idx_d   = '0;
        end
      end
      default: state_d = ARB_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_FREE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign grant_vld = (state_q == ARB_OWNED);
  assign grant_idx = idx_q;

  for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_dec
    assign grant[k] = grant_vld && (idx_q == IDX_W'(k));
  end

  // R5
  grant_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && any_req) |=> (grant_vld && grant_idx == $past(win_idx)));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !done[grant_idx]) |=> (grant_vld && $stable(grant_idx)));

  // R7
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && done[grant_idx]) |=> !grant_vld);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && !any_req) |=> (!grant_vld && grant_idx == '0));

endmodule

// File: rtl/stream_prio_arbiter.sv
module stream_prio_arbiter #(
  parameter int NUM_STREAMS = 8,
  parameter int LVL_W       = 2,
  parameter int CTRL_W      = 32,
  parameter int PRIO_LSB    = 16,
  localparam int IDX_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] req_i,
  input  logic [NUM_STREAMS-1:0] done_i,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_sel_i,
  input  logic [CTRL_W-1:0]      cfg_wdata_i,
  output logic [NUM_STREAMS-1:0] grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   grant_vld_o
);

  logic [NUM_STREAMS-1:0][LVL_W-1:0] prio_q;
  logic                              any_req;
  logic [IDX_W-1:0]                  win_idx;

  sarb_prio_regs #(
    .NUM_STREAMS (NUM_STREAMS),
    .LVL_W       (LVL_W),
    .CTRL_W      (CTRL_W),
    .PRIO_LSB    (PRIO_LSB),
    .IDX_W       (IDX_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we_i),
    .wr_sel  (cfg_sel_i),
    .wr_data (cfg_wdata_i),
    .prio_q  (prio_q)
  );

  sarb_select #(
    .NUM_STREAMS (NUM_STREAMS),
    .LVL_W       (LVL_W),
    .IDX_W       (IDX_W)
  ) sel_i (
    .req     (req_i),
    .prio    (prio_q),
    .any_req (any_req),
    .win_idx (win_idx)
  );

  sarb_grant_hold #(
    .NUM_STREAMS (NUM_STREAMS),
    .IDX_W       (IDX_W)
  ) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .win_idx   (win_idx),
    .done      (done_i),
    .grant     (grant_o),
    .grant_idx (grant_idx_o),
    .grant_vld (grant_vld_o)
  );

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ($countones(grant_o) == 1 && grant_o[grant_idx_o]));

  // R9
  grant_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld_o |-> (grant_o == '0));

  // R8
  grant_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && cfg_we_i && !done_i[grant_idx_o]) |=> $stable(grant_o));

endmodule

// File: tb/stream_prio_arbiter_tb_top.sv
module stream_prio_arbiter_tb_top;

  localparam int  N       = 8;
  localparam time CLK_PER = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_i;
  logic [N-1:0] done_i;
  logic         cfg_we_i;
  logic [2:0]   cfg_sel_i;
  logic [31:0]  cfg_wdata_i;
  logic [N-1:0] grant_o;
  logic [2:0]   grant_idx_o;
  logic         grant_vld_o;

  int total = 0;
  int bad   = 0;
  int mprio [N];

  always #(CLK_PER / 2) clk = ~clk;

  stream_prio_arbiter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .done_i      (done_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .grant_o     (grant_o),
    .grant_idx_o (grant_idx_o),
    .grant_vld_o (grant_vld_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected winner: highest level first, lowest index on equal level
  function automatic int exp_winner(input logic [N-1:0] pat);
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (pat[i] && (best < 0 || mprio[i] > mprio[best])) best = i;
    end
    return best;
  endfunction

  task automatic write_prio(input int s, input int lvl, input logic [31:0] junk);
    cfg_we_i    = 1'b1;
    cfg_sel_i   = 3'(s);
    cfg_wdata_i = junk;
    cfg_wdata_i[17:16] = 2'(lvl);
    @(negedge clk);
    cfg_we_i    = 1'b0;
    cfg_wdata_i = ~junk;
    mprio[s]    = lvl;
  endtask

  task automatic expect_grant(input string tag, input int w);
    check({tag, " vld"}, 32'(grant_vld_o), 32'(1));
    check({tag, " idx"}, 32'(grant_idx_o), 32'(w));
    check({tag, " onehot"}, 32'(grant_o), 32'(1 << w));
  endtask

  task automatic expect_free(input string tag);
    check({tag, " vld"}, 32'(grant_vld_o), 32'(0));
    check({tag, " grant"}, 32'(grant_o), 32'(0));
    check({tag, " idx"}, 32'(grant_idx_o), 32'(0));
  endtask

  task automatic trial(input logic [N-1:0] pat);
    int w;
    w = exp_winner(pat);
    req_i = pat;
    @(negedge clk);
    if (w < 0) begin
      expect_free("R9 no request");
    end else begin
      expect_grant("R3/R4 winner", w);
      // R6: other requests and foreign done pulses change nothing
      req_i  = ~pat;
      done_i = ~(N'(1) << w);
      @(negedge clk);
      expect_grant("R6 hold", w);
      // R7: owner done releases
      req_i  = '0;
      done_i = N'(1) << w;
      @(negedge clk);
      done_i = '0;
      expect_free("R7 release");
    end
    req_i = '0;
  endtask

  function automatic int cfg_level(input int c, input int i);
    case (c)
      0:       return 0;
      1:       return i % 4;
      2:       return 3 - (i % 4);
      default: return (5 * i + 3) % 4;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    req_i       = '0;
    done_i      = '0;
    cfg_we_i    = 1'b0;
    cfg_sel_i   = '0;
    cfg_wdata_i = '0;
    for (int i = 0; i < N; i++) mprio[i] = 0;
    repeat (3) @(negedge clk);
    expect_free("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_free("R1 after reset");

    // R1: all levels low after reset, so the lowest index wins everything
    trial(8'hFF);
    trial(8'h90);

    // R9: idle with a stray done stays quiet
    done_i = 8'hFF;
    @(negedge clk);
    done_i = '0;
    @(negedge clk);
    expect_free("R9 idle done");

    // R2/R3/R4: sweep every pattern under several level assignments
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < N; i++) write_prio(i, cfg_level(c, i), 32'hFFFC_FFFF ^ 32'(c * 7 + i));
      for (int p = 0; p < 256; p++) trial(8'(p));
    end

    // R2: junk outside [17:16] ignored; stream 6 at very high beats all-low rivals
    for (int i = 0; i < N; i++) write_prio(i, 0, 32'hFFFC_FFFF);
    write_prio(6, 3, 32'h0000_0000);
    trial(8'hFF);
    write_prio(6, 1, 32'hFFFC_FFFF);
    write_prio(2, 2, 32'h5A5A_5A5A);
    trial(8'h44);

    // R8: priority write during a grant does not move it, applies next decision
    for (int i = 0; i < N; i++) write_prio(i, 0, 32'h0);
    req_i = 8'h20;
    @(negedge clk);
    expect_grant("R8 owner", 5);
    req_i = 8'h28;
    write_prio(3, 3, 32'h0);
    expect_grant("R8 after write", 5);
    write_prio(5, 0, 32'hFFFF_FFFF);
    expect_grant("R8 after second write", 5);
    // R7: done with requests pending -> one free cycle, then re-arbitrate
    done_i = 8'h20;
    @(negedge clk);
    done_i = '0;
    expect_free("R7 gap");
    @(negedge clk);
    expect_grant("R8/R7 new decision", 3);
    req_i  = '0;
    done_i = 8'h08;
    @(negedge clk);
    done_i = '0;
    expect_free("R7 final release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule